// File: doc/BRIEF.md
# Synchronous divide-by-2/4/8 clock generator

The block derives three clocks from one input clock: one at half, one at a quarter and one at an eighth of the input rate. All three taps are bits of a single counter that steps on the rising edge of the input clock. Because of this, every rising edge that two taps share lands on the same input edge, and no tap can ripple behind another.

An enable input gates the counter. A flop clocked on the falling input edge samples the enable, so the gate can only open or close while the input clock is low. A divided clock pulse therefore always runs its full length and is never cut short. While gated, every tap holds its level. When counting resumes, it continues from the held count.

An active-low asynchronous master reset clears the counter and the enable flop. Several instances that share the reset release together with identical phase.

Top module: `clkdiv248`

## Requirements
- R1: q_div2_o is counter bit 0. It toggles on every rising edge of clk_i at which the sampled enable is high, which divides clk_i by 2 while enabled.
- R2: q_div4_o is counter bit 1. It toggles only on a rising clk_i edge where q_div2_o falls from 1 to 0, which divides by 4.
- R3: q_div8_o is counter bit 2. It toggles only on a rising clk_i edge where q_div4_o falls from 1 to 0, which divides by 8.
- R4: While rst_ni is low, all three outputs are 0 and the sampled enable is 0. The clear takes effect at once, without waiting for a clock edge.
- R5: After rst_ni is released with en_i high, the counter steps up by one on each enabled rising edge. The outputs form the binary count {q_div8_o,q_div4_o,q_div2_o} = 1, 2, 3, … 7, 0, and so on. The first enabled edge raises only q_div2_o.
- R6: en_i is sampled only on the falling edge of clk_i. A change made just after a falling edge has no effect on the next rising edge. It first affects the rising edge that follows the next falling edge.
- R7: While the sampled enable is low, all outputs hold their level. When it returns high, the count resumes from the held value with no step skipped.
- R8: Under any pattern of en_i changes, no high or low period of a tap is shorter than its nominal half period: 1, 2 and 4 clk_i cycles for q_div2_o, q_div4_o and q_div8_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| en_i | input | 1 | Count enable, sampled on the falling clk_i edge |
| q_div2_o | output | 1 | Input clock divided by 2 |
| q_div4_o | output | 1 | Input clock divided by 4 |
| q_div8_o | output | 1 | Input clock divided by 8 |

## Verification
A long run with the enable held high walks the counter through two full wraps. This separates a correct binary sequence and tap ordering from swapped or misrouted bits. Holding the enable low for several cycles shows whether the taps freeze and whether counting resumes without a skipped step. Changing the enable just after a falling edge separates sampling on the falling edge from sampling on the rising edge, because the two give a step one cycle apart. Random enable toggling, combined with a run-length monitor, shows that gating can only stretch a divided clock and never shortens one. A reset asserted between clock edges shows that the clear does not wait for a clock edge.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  parameter int unsigned DIV_STAGES = 3;
  typedef logic [DIV_STAGES-1:0] div_cnt_t;
endpackage

// File: rtl/clkdiv_en_sync.sv
// Enable capture on the falling edge: the gate moves only while clk is low.
module clkdiv_en_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic en_q_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q_o <= 1'b0;
    else         en_q_o <= en_i;
  end
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [WIDTH-1:0] cnt_o
);
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] cnt_q;

  assign carry[0] = step_i;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    assign carry[i+1] = carry[i] & cnt_q[i];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q[i] <= 1'b0;
      else if (carry[i]) cnt_q[i] <= ~cnt_q[i];
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/clkdiv248.sv
module clkdiv248
  import clkdiv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic q_div2_o,
  output logic q_div4_o,
  output logic q_div8_o
);
  logic     en_q;
  div_cnt_t cnt;

  clkdiv_en_sync u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .en_q_o (en_q)
  );

  clkdiv_counter #(.WIDTH(DIV_STAGES)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (en_q),
    .cnt_o  (cnt)
  );

  assign q_div2_o = cnt[0];
  assign q_div4_o = cnt[1];
  assign q_div8_o = cnt[2];
endmodule

// File: rtl/clkdiv248_chk.sv
module clkdiv248_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       en_q,
  input logic [2:0] cnt
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  p_step_on_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && en_q |=> cnt == 3'($past(cnt) + 3'd1));

  p_hold_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && !en_q |=> $stable(cnt));

  p_div4_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && (cnt[1] != $past(cnt[1])) |-> $fell(cnt[0]));

  p_div8_edge_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok && (cnt[2] != $past(cnt[2])) |-> $fell(cnt[1]));

  p_reset_clear_r4: assert property (@(posedge clk_i)
    !rst_ni |-> (cnt == 3'd0 && !en_q));
endmodule

bind clkdiv248 clkdiv248_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .en_q   (en_q),
  .cnt    (cnt)
);

// File: tb/clkdiv248_tb.sv
`timescale 1ns/100ps
module clkdiv248_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic en = 1'b0;
  logic q2, q4, q8;
  int   n_tot = 0;
  int   n_bad = 0;
  logic [2:0] exp_cnt = 3'd0;
  logic mon_on = 1'b0;

  clkdiv248 u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en),
    .q_div2_o(q2), .q_div4_o(q4), .q_div8_o(q8)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
    n_tot++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Called at posedge+1: drive en, advance one rising edge, check.
  task automatic step(input logic e, input string req);
    en = e;
    @(posedge clk); #1;
    if (e) exp_cnt = exp_cnt + 3'd1;
    chk(req, {q8, q4, q2}, exp_cnt);
  endtask

  task automatic do_reset();
    en = 1'b1;
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1;
    chk("R4 async clear", {q8, q4, q2}, 3'd0);
    @(posedge clk); #1;
    chk("R4 held in reset", {q8, q4, q2}, 3'd0);
    rst_n = 1'b1;
    exp_cnt = 3'd0;
  endtask

  task automatic t_count();
    do_reset();
    step(1'b1, "R5 first edge only q_div2");
    for (int i = 0; i < 16; i++) begin
      step(1'b1, "R1 R2 R3 R5 count");
    end
  endtask

  task automatic t_hold();
    for (int i = 0; i < 3; i++) step(1'b1, "R7 pre");
    en = 1'b0;
    @(negedge clk); #1;
    @(posedge clk); #1;
    for (int i = 0; i < 5; i++) step(1'b0, "R7 hold");
    // en was sampled at the last negedge; resumes at the following posedge
    step(1'b1, "R7 resume no skip");
    step(1'b1, "R7 resume next");
  endtask

  task automatic t_late_en();
    logic [2:0] held;
    en = 1'b0;
    @(posedge clk); #1;
    @(posedge clk); #1;
    held = {q8, q4, q2};
    exp_cnt = held;
    @(negedge clk); #1;
    en = 1'b1;
    @(posedge clk); #1;
    chk("R6 no step before next fall", {q8, q4, q2}, held);
    @(posedge clk); #1;
    exp_cnt = held + 3'd1;
    chk("R6 step after sampling fall", {q8, q4, q2}, exp_cnt);
    @(negedge clk); #1;
    en = 1'b0;
    @(posedge clk); #1;
    exp_cnt = exp_cnt + 3'd1;
    chk("R6 still counts before fall", {q8, q4, q2}, exp_cnt);
    @(posedge clk); #1;
    chk("R6 frozen after fall", {q8, q4, q2}, exp_cnt);
  endtask

  task automatic t_random();
    @(posedge clk); #1;
    mon_on = 1'b1;
    for (int i = 0; i < 400; i++) begin
      step(1'($urandom_range(0, 1)), "R7 R8 random");
    end
    mon_on = 1'b0;
  endtask

  // R8 run-length monitor
  int   run [3];
  logic lvl [3];
  logic seen[3];
  logic mon_prev = 1'b0;
  always @(negedge clk) begin
    logic [2:0] q;
    q = {q8, q4, q2};
    if (mon_on) begin
      for (int i = 0; i < 3; i++) begin
        if (!mon_prev) begin
          lvl[i] = q[i]; run[i] = 1; seen[i] = 1'b0;
        end else if (q[i] != lvl[i]) begin
          if (seen[i]) begin
            n_tot++;
            if (run[i] < (1 << i)) begin
              n_bad++;
              $display("FAIL R8 tap%0d run: actual=%0d expected>=%0d", i, run[i], 1 << i);
            end
          end
          seen[i] = 1'b1; run[i] = 1; lvl[i] = q[i];
        end else begin
          run[i]++;
        end
      end
    end
    mon_prev = mon_on;
  end

  initial begin
    #1 rst_n = 1'b0;
    #1 chk("R4 reset state", {q8, q4, q2}, 3'd0);
    @(posedge clk); #1;
    chk("R4 reset state clocked", {q8, q4, q2}, 3'd0);
    rst_n = 1'b1;
    t_count();
    t_hold();
    t_late_en();
    t_random();
    do_reset();
    step(1'b1, "R5 after second reset");
    step(1'b1, "R5 after second reset");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end

  initial begin
    #200000;
    n_tot++;
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", n_tot, n_bad);
    $finish;
  end
endmodule